// File: doc/BRIEF.md
# DMA Channel FIFO Setup Sequencer

This block programs one DMA channel's on-chip FIFO through a plain write bus. A single start strobe latches the channel's layout: where its command block lives, where its control area lives, where the FIFO begins and how large it is, the addresses of the channel's two pointer registers and two count registers, the program address, and the requested bytes per line. The block then derives the line geometry and emits every setup write itself, one word per accepted handshake.

The requested line size is first rounded up to the next multiple of 8 bytes. The FIFO is divided into as many whole lines as fit. The descriptor table sits 64 bytes past the control base, which leaves room for the instruction queue ahead of it. The block writes one descriptor per line, then the 16-word command block, then the four channel registers. A one-cycle done pulse follows the last accepted write. If not even one line fits, the descriptor writes are skipped and an error flag is raised, but the rest of the sequence still runs.

Top module: `fifo_chan_setup`

## Requirements
- R1: The line size used everywhere is the requested bytes per line rounded up to a multiple of 8.
- R2: The number of lines is the FIFO size divided by the rounded line size, discarding any remainder, and exactly that many descriptor writes are issued.
- R3: Descriptor k is written at address (control base + 64 + 16·k) with data (FIFO start + k·line size).
- R4: The command block word at byte offset 0 holds the program address, offset 4 holds the descriptor table base (control base + 64), offset 8 holds 2·lines, offset 12 holds the control base and offset 16 holds the value 16.
- R5: Command block offsets 20 through 60, in steps of 4, are written with zero.
- R6: The four channel registers receive the following values: pointer 1 gets the FIFO start, pointer 2 gets the table base, count 1 gets (line size / 8) − 1, and count 2 gets 2·lines.
- R7: The writes are issued in a fixed order. All descriptors come first, in ascending order. The command block follows, at ascending offsets. Last come pointer 1, pointer 2, count 1 and count 2.
- R8: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values. Each cycle with both high transfers exactly one write.
- R9: done is high for exactly the one cycle after the last write is accepted. busy is high from the cycle after start until then. A start pulse seen while busy is high is ignored.
- R10: If the rounded line size is zero or larger than the FIFO size, no descriptor writes are issued and err goes high. err stays high until the next accepted start, and the command block and register writes still follow.
- R11: After reset, wr_valid, busy, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latches the parameters and begins a sequence when idle |
| cmd_base | input | 32 | Command block base address |
| ctrl_base | input | 32 | Control area base; the descriptor table starts 64 bytes above it |
| fifo_base | input | 32 | First byte of the FIFO |
| fifo_bytes | input | 32 | FIFO size in bytes |
| ptr1_reg | input | 32 | Address of pointer register 1 |
| ptr2_reg | input | 32 | Address of pointer register 2 |
| cnt1_reg | input | 32 | Address of count register 1 |
| cnt2_reg | input | 32 | Address of count register 2 |
| line_bytes | input | 16 | Requested bytes per line |
| prog_addr | input | 32 | Program start address for the command block |
| wr_valid | output | 1 | A write is presented |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Sink accepts the presented write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final write |
| err | output | 1 | No line fits in the FIFO |

## Verification
The hardest situations to reach from the ports are two. The first is a stalled handshake at the exact moment the sequence changes phase: between the last descriptor and the first command word, and between the command block and the registers. The second is a start pulse that arrives in the middle of a sequence. The bench drives wr_ready from a free-running shift register during a case with many lines, so stalls fall across both phase boundaries. It checks that every word stays stable while it is held. A separate case drives a second start, with different parameters, ten cycles into a run and checks that the captured write stream still matches the first parameter set. The error cases are reached with a zero request and with a request one step larger than the FIFO.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    parameter int FCS_W = 32;

    localparam int CMD_WORDS   = 16;
    localparam int REG_WORDS   = 4;
    localparam int DESC_STRIDE = 16;
    localparam int QUEUE_BYTES = 64;
    localparam int WORD_BYTES  = 4;
    localparam int ALIGN_BYTES = 8;

    typedef logic [FCS_W-1:0] word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DIV,
        PH_DESC,
        PH_CMD,
        PH_REG
    } phase_e;

    typedef struct packed {
        word_t cmd_base;
        word_t ctrl_base;
        word_t fifo_base;
        word_t fifo_bytes;
        word_t ptr1;
        word_t ptr2;
        word_t cnt1;
        word_t cnt2;
        word_t prog;
        word_t aligned;
    } chan_cfg_t;

    function automatic word_t round_up8(word_t v);
        return (v + word_t'(ALIGN_BYTES - 1)) & ~word_t'(ALIGN_BYTES - 1);
    endfunction

    // (lines * 16) / 8 expressed as a shift
    function automatic word_t lines_to_qwords(word_t n);
        return n << 1;
    endfunction
endpackage

// File: rtl/fcs_linediv.sv
module fcs_linediv
    import fcs_pkg::*;
#(
    parameter int W = FCS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  dvs;
    logic [CW-1:0] left;
    logic          run;
    logic [W:0]    shifted;

    assign shifted = {rem[W-1:0], quot[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            dvs  <= '0;
            left <= '0;
            run  <= 1'b0;
            fin  <= 1'b0;
            quot <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem  <= '0;
                dvs  <= den;
                left <= CW'(W);
                if (den == '0 || den > num) begin
                    quot <= '0;
                    run  <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    quot <= num;
                    run  <= 1'b1;
                end
            end else if (run) begin
                if (shifted >= {1'b0, dvs}) begin
                    rem  <= shifted - {1'b0, dvs};
                    quot <= {quot[W-2:0], 1'b1};
                end else begin
                    rem  <= shifted;
                    quot <= {quot[W-2:0], 1'b0};
                end
                left <= left - CW'(1);
                if (left == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    // R2
    div_rem_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> rem < {1'b0, dvs});
endmodule

// File: rtl/fcs_wordgen.sv
module fcs_wordgen
    import fcs_pkg::*;
(
    input  phase_e    phase,
    input  word_t     idx,
    input  chan_cfg_t cfg,
    input  word_t     lines,
    input  word_t     desc_addr,
    input  word_t     desc_data,
    output word_t     addr,
    output word_t     data
);
    word_t tbl_base;
    assign tbl_base = cfg.ctrl_base + word_t'(QUEUE_BYTES);

    always_comb begin
        addr = '0;
        data = '0;
        case (phase)
            PH_DESC: begin
                addr = desc_addr;
                data = desc_data;
            end
            PH_CMD: begin
                addr = cfg.cmd_base + (idx << 2);
                case (idx)
                    word_t'(0): data = cfg.prog;
                    word_t'(1): data = tbl_base;
                    word_t'(2): data = lines_to_qwords(lines);
                    word_t'(3): data = cfg.ctrl_base;
                    word_t'(4): data = word_t'(QUEUE_BYTES / WORD_BYTES);
                    default:    data = '0;
                endcase
            end
            PH_REG: begin
                case (idx[1:0])
                    2'd0: begin addr = cfg.ptr1; data = cfg.fifo_base; end
                    2'd1: begin addr = cfg.ptr2; data = tbl_base; end
                    2'd2: begin addr = cfg.cnt1; data = (cfg.aligned >> 3) - word_t'(1); end
                    default: begin addr = cfg.cnt2; data = lines_to_qwords(lines); end
                endcase
            end
            default: begin
                addr = '0;
                data = '0;
            end
        endcase
    end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import fcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  chan_cfg_t cfg_in,
    input  logic      div_fin,
    input  word_t     div_quot,
    input  logic      wr_ready,
    output logic      div_go,
    output phase_e    phase,
    output chan_cfg_t cfg,
    output word_t     idx,
    output word_t     lines,
    output word_t     desc_addr,
    output word_t     desc_data,
    output logic      wr_valid,
    output logic      busy,
    output logic      done,
    output logic      err
);
    logic accept;

    assign div_go   = (phase == PH_IDLE) && start;
    assign wr_valid = (phase == PH_DESC) || (phase == PH_CMD) || (phase == PH_REG);
    assign busy     = (phase != PH_IDLE);
    assign accept   = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg       <= '0;
            idx       <= '0;
            lines     <= '0;
            desc_addr <= '0;
            desc_data <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cfg   <= cfg_in;
                        err   <= 1'b0;
                        phase <= PH_DIV;
                    end
                end
                PH_DIV: begin
                    if (div_fin) begin
                        lines     <= div_quot;
                        err       <= (div_quot == '0);
                        desc_addr <= cfg.ctrl_base + word_t'(QUEUE_BYTES);
                        desc_data <= cfg.fifo_base;
                        idx       <= '0;
                        phase     <= (div_quot == '0) ? PH_CMD : PH_DESC;
                    end
                end
                PH_DESC: begin
                    if (accept) begin
                        desc_addr <= desc_addr + word_t'(DESC_STRIDE);
                        desc_data <= desc_data + cfg.aligned;
                        if (idx == lines - word_t'(1)) begin
                            idx   <= '0;
                            phase <= PH_CMD;
                        end else begin
                            idx <= idx + word_t'(1);
                        end
                    end
                end
                PH_CMD: begin
                    if (accept) begin
                        if (idx == word_t'(CMD_WORDS - 1)) begin
                            idx   <= '0;
                            phase <= PH_REG;
                        end else begin
                            idx <= idx + word_t'(1);
                        end
                    end
                end
                PH_REG: begin
                    if (accept) begin
                        if (idx == word_t'(REG_WORDS - 1)) begin
                            idx   <= '0;
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + word_t'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    desc_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DESC) |-> (idx < lines));

    // R10
    err_no_desc_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (phase != PH_DESC));

    // R7
    cmd_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD) |-> (idx < word_t'(CMD_WORDS)));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);
endmodule

// File: rtl/fifo_chan_setup.sv
module fifo_chan_setup
    import fcs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [FCS_W-1:0] cmd_base,
    input  logic [FCS_W-1:0] ctrl_base,
    input  logic [FCS_W-1:0] fifo_base,
    input  logic [FCS_W-1:0] fifo_bytes,
    input  logic [FCS_W-1:0] ptr1_reg,
    input  logic [FCS_W-1:0] ptr2_reg,
    input  logic [FCS_W-1:0] cnt1_reg,
    input  logic [FCS_W-1:0] cnt2_reg,
    input  logic [LEN_W-1:0] line_bytes,
    input  logic [FCS_W-1:0] prog_addr,
    output logic             wr_valid,
    output logic [FCS_W-1:0] wr_addr,
    output logic [FCS_W-1:0] wr_data,
    input  logic             wr_ready,
    output logic             busy,
    output logic             done,
    output logic             err
);
    chan_cfg_t cfg_in, cfg;
    phase_e    phase;
    word_t     idx, lines, desc_addr, desc_data, div_quot;
    logic      div_go, div_fin;

    always_comb begin
        cfg_in.cmd_base   = cmd_base;
        cfg_in.ctrl_base  = ctrl_base;
        cfg_in.fifo_base  = fifo_base;
        cfg_in.fifo_bytes = fifo_bytes;
        cfg_in.ptr1       = ptr1_reg;
        cfg_in.ptr2       = ptr2_reg;
        cfg_in.cnt1       = cnt1_reg;
        cfg_in.cnt2       = cnt2_reg;
        cfg_in.prog       = prog_addr;
        cfg_in.aligned    = round_up8(word_t'(line_bytes));
    end

    fcs_linediv #(.W(FCS_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (cfg_in.fifo_bytes),
        .den  (cfg_in.aligned),
        .fin  (div_fin),
        .quot (div_quot)
    );

    fcs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg_in),
        .div_fin   (div_fin),
        .div_quot  (div_quot),
        .wr_ready  (wr_ready),
        .div_go    (div_go),
        .phase     (phase),
        .cfg       (cfg),
        .idx       (idx),
        .lines     (lines),
        .desc_addr (desc_addr),
        .desc_data (desc_data),
        .wr_valid  (wr_valid),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    fcs_wordgen u_gen (
        .phase     (phase),
        .idx       (idx),
        .cfg       (cfg),
        .lines     (lines),
        .desc_addr (desc_addr),
        .desc_data (desc_data),
        .addr      (wr_addr),
        .data      (wr_data)
    );

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);
endmodule

// File: tb/fifo_chan_setup_test.sv
module fifo_chan_setup_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cmd_base = '0, ctrl_base = '0, fifo_base = '0, fifo_bytes = '0;
    logic [31:0] ptr1_reg = '0, ptr2_reg = '0, cnt1_reg = '0, cnt2_reg = '0;
    logic [15:0] line_bytes = '0;
    logic [31:0] prog_addr = '0;
    logic        wr_valid, busy, done, err;
    logic [31:0] wr_addr, wr_data;
    logic        wr_ready = 1'b1;

    always #2 clk = ~clk;

    fifo_chan_setup uut (
        .clk(clk), .rst(rst), .start(start),
        .cmd_base(cmd_base), .ctrl_base(ctrl_base), .fifo_base(fifo_base),
        .fifo_bytes(fifo_bytes), .ptr1_reg(ptr1_reg), .ptr2_reg(ptr2_reg),
        .cnt1_reg(cnt1_reg), .cnt2_reg(cnt2_reg), .line_bytes(line_bytes),
        .prog_addr(prog_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_a [0:255];
    logic [31:0] exp_d [0:255];
    int          exp_n;
    logic        exp_err;
    logic [31:0] obs_a [0:255];
    logic [31:0] obs_d [0:255];
    int          obs_n = 0;
    int          done_seen = 0;
    int          done_cyc = 0;
    int          last_acc = 0;
    int          hold_err = 0;
    int          cyc = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_a = '0, prev_d = '0;
    logic        stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        if (prev_stall && (!wr_valid || wr_addr != prev_a || wr_data != prev_d))
            hold_err++;
        prev_stall = wr_valid && !wr_ready;
        prev_a = wr_addr;
        prev_d = wr_data;
        if (wr_valid && wr_ready) begin
            if (obs_n < 256) begin
                obs_a[obs_n] = wr_addr;
                obs_d[obs_n] = wr_data;
            end
            obs_n++;
            last_acc = cyc;
        end
        if (done) begin
            done_seen++;
            done_cyc = cyc;
        end
        cyc++;
    end

    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_ready <= stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_expected(input logic [31:0] cb, cr, fb, fs, input logic [15:0] req, input logic [31:0] pg,
                                  input logic [31:0] p1, p2, c1, c2);
        logic [31:0] al, nl, tb;
        al = ({16'h0, req} + 32'd7) & ~32'd7;
        nl = (al == 0 || al > fs) ? 32'd0 : fs / al;
        tb = cr + 32'd64;
        exp_n = 0;
        exp_err = (nl == 0);
        for (int k = 0; k < int'(nl); k++) push(tb + 32'(16 * k), fb + 32'(k) * al);
        push(cb + 32'd0, pg);
        push(cb + 32'd4, tb);
        push(cb + 32'd8, nl * 2);
        push(cb + 32'd12, cr);
        push(cb + 32'd16, 32'd16);
        for (int o = 20; o <= 60; o += 4) push(cb + 32'(o), 32'd0);
        push(p1, fb);
        push(p2, tb);
        push(c1, (al >> 3) - 32'd1);
        push(c2, nl * 2);
    endtask

    task automatic run_case(input string tag, input logic [31:0] cb, cr, fb, fs, input logic [15:0] req,
                            input logic [31:0] pg, input bit stall, input bit interrupt);
        int mism, first, waited;
        build_expected(cb, cr, fb, fs, req, pg, 32'h00310000, 32'h00310004, 32'h00310008, 32'h0031000C);
        @(negedge clk);
        stall_mode = stall;
        cmd_base = cb; ctrl_base = cr; fifo_base = fb; fifo_bytes = fs;
        line_bytes = req; prog_addr = pg;
        ptr1_reg = 32'h00310000; ptr2_reg = 32'h00310004; cnt1_reg = 32'h00310008; cnt2_reg = 32'h0031000C;
        obs_n = 0; done_seen = 0; hold_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R9 busy after start"}, 32'(busy), 32'd1);
        if (interrupt) begin
            repeat (10) @(negedge clk);
            cmd_base = 32'hDEAD0000; fifo_base = 32'h0BAD0000; line_bytes = 16'd8; prog_addr = 32'h12345678;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_seen == 0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk(obs_n == exp_n, {tag, " R2 R7 write count"}, 32'(obs_n), 32'(exp_n));
        mism = 0;
        first = -1;
        for (int k = 0; k < exp_n && k < obs_n; k++)
            if (obs_a[k] != exp_a[k] || obs_d[k] != exp_d[k]) begin
                mism++;
                if (first < 0) first = k;
            end
        if (first >= 0)
            chk(1'b0, {tag, " R1 R3 R4 R5 R6 R7 write stream"}, obs_d[first], exp_d[first]);
        else
            chk(1'b1, {tag, " R1 R3 R4 R5 R6 R7 write stream"}, 32'(mism), 32'd0);
        chk(err == exp_err, {tag, " R10 err flag"}, 32'(err), 32'(exp_err));
        chk(done_seen == 1 && done_cyc == last_acc + 1, {tag, " R9 done pulse timing"},
            32'(done_cyc), 32'(last_acc + 1));
        chk(hold_err == 0, {tag, " R8 held write stable"}, 32'(hold_err), 32'd0);
        chk(busy == 1'b0 && wr_valid == 1'b0, {tag, " R9 idle after done"}, 32'({busy, wr_valid}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(wr_valid == 1'b0, "R11 wr_valid after reset", 32'(wr_valid), 32'd0);
        chk(busy == 1'b0, "R11 busy after reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R11 done after reset", 32'(done), 32'd0);
        chk(err == 1'b0, "R11 err after reset", 32'(err), 32'd0);

        // R1 R2 R3 R4 R5 R6 R7: wide line, 3 lines, no stalls
        run_case("wide", 32'h00180040, 32'h00180400, 32'h00180C00, 32'h00002800, 16'd2880, 32'h00400000, 1'b0, 1'b0);
        // R1 R8: 100 rounds to 104, 19 lines, stalled sink
        run_case("round", 32'h00180080, 32'h001804A0, 32'h00183400, 32'h00000800, 16'd100, 32'h00401000, 1'b1, 1'b0);
        // R10: line larger than FIFO
        run_case("toolong", 32'h001800C0, 32'h00180540, 32'h00183C00, 32'h00000800, 16'h0801, 32'h00402000, 1'b1, 1'b0);
        // R2: line exactly equals FIFO, one line
        run_case("exact", 32'h00180100, 32'h001805E0, 32'h00184400, 32'h00000800, 16'h0800, 32'h00403000, 1'b0, 1'b0);
        // R10: zero request
        run_case("zero", 32'h00180140, 32'h00180680, 32'h00185400, 32'h00001000, 16'd0, 32'h00404000, 1'b0, 1'b0);
        // R9: start while busy is ignored; 1 rounds to 8, 8 lines
        run_case("restart", 32'h00180200, 32'h001807C0, 32'h00186400, 32'h00000040, 16'd1, 32'h00405000, 1'b1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule